// File: doc/BRIEF.md
# Parallel NOR Flash Host Bus Front End

This block is a clock-synchronous model of the host-facing control logic of a parallel NOR boot-block flash. It watches the active-low chip-select, output-enable, write-strobe and power/reset pins, a word address bus and a 16-bit data bus. The data bus is split into an input half and an output half with two lane enables, so the pad ring can form the bidirectional pins.

Write cycles are captured on the rising edge of the write strobe and decoded as commands. A command can select the read source: array data, the status byte, or a two-word signature. Signature reads can also be forced by a high-voltage flag on an address pin.

A two-write program sequence and a two-write erase sequence start a fixed busy window. While the window runs, the status byte shows not-ready. Requests aimed at the boot region are refused unless the boot region is opened, either by the unlock flag of the reset pin or by the write-protect pin. The array sits behind a plain synchronous port: its read data returns one clock after the address. The port has no handshake and applies no back-pressure.

Top module: `flash_host_front`

## Requirements
- R1: A write is taken in the clock cycle in which `wr_en_n` goes from low to high while `chip_sel_n` is low. The address and data presented in that cycle are captured. A strobe with `chip_sel_n` high has no effect.
- R2: Program takes two writes. The first write carries command 0x40 (0x10 is also accepted). The second write stores its data at its address through `mem_we`. In word mode both byte enables are set. In byte mode only the lane chosen by `dq_in[15]` is written, with the data taken from `dq_in[7:0]`.
- R3: `dq_oe_lo` and `dq_oe_hi` are both low whenever `chip_sel_n` or `out_en_n` is high.
- R4: While `pwr_rst_n` is low, both output enables are low and the command logic is held in reset. After `pwr_rst_n` rises, reads return array data and the status byte reads 0x80.
- R5: While `sig_hv` is high, reads return the signature whatever the command mode is. `addr[0]`=0 gives the maker code 0x0051 and `addr[0]`=1 gives the part code 0x22D6.
- R6: While `byte_sel_n` is low, `dq_oe_hi` stays low and `dq_out[15:8]` is zero. For array reads, `dq_in[15]`=0 returns the low byte of the word on `dq_out[7:0]` and `dq_in[15]`=1 returns the high byte.
- R7: For signature reads in byte mode, only the low byte of the code is returned and `dq_in[15]` is ignored.
- R8: With `rst_unlock` high, program and erase of the boot region (word addresses below `BOOT_WORDS`, default 64) proceed even when `wr_prot_n` is low.
- R9: With `rst_unlock` low and `wr_prot_n` low, a program aimed at the boot region leaves the array unchanged and the status byte reads 0x92. A blocked erase makes the status byte read 0xA2.
- R10: Command 0x70 switches reads to the status byte on `dq_out[7:0]`. The status bits are: bit 7 ready, bit 5 erase error, bit 4 program error, bit 1 lock error. Command 0x50 clears the error bits and keeps the current read mode. Command 0xFF, or any byte that is not a command, selects array reads.
- R11: A launched program or erase keeps the block busy for `BUSY_CYCLES` clocks, with status bit 7 low. Every write taken during that window is ignored. This includes a new program command.
- R12: Erase is 0x20 followed by 0xD0. Any other second byte aborts the erase and makes the status byte read 0xB0.
- R13: After the second write of a program or erase, reads return the status byte until a command selects another read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| pwr_rst_n | input | 1 | Reset/power-down pin, low = reset |
| rst_unlock | input | 1 | Reset pin at unlock level (high-voltage flag) |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_prot_n | input | 1 | Write protect, low protects the boot region |
| sig_hv | input | 1 | Address pin at high-voltage level: signature reads |
| byte_sel_n | input | 1 | Low selects byte-wide bus |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data bus input; bit 15 is the byte-lane address in byte mode |
| dq_out | output | 16 | Data bus output value |
| dq_oe_lo | output | 1 | Drive enable for bus bits 7..0 |
| dq_oe_hi | output | 1 | Drive enable for bus bits 15..8 |
| mem_addr | output | AW | Array word address |
| mem_we | output | 1 | Array write pulse |
| mem_be | output | 2 | Array byte enables |
| mem_wdata | output | 16 | Array write data |
| mem_rdata | input | 16 | Array read data, one clock after `mem_addr` |

## Verification
The hardest case to reach from the pins is a command that lands inside the busy window. The proof that it was ignored also only appears later, because a dropped program command changes nothing until the write that would have been its data arrives. The stimulus issues a program, then issues a second program command straight after it, in back-to-back strobe cycles well inside the window. After ready returns it writes a data word. That word must be decoded as a plain command, and the array must keep the first value. A reset pulled in the middle of a busy window is driven in the same way: the bench pulls the pin low, then checks read mode and status after the pin rises.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2
  } rd_src_e;

  typedef enum logic [1:0] {
    M_ARRAY    = 2'd0,
    M_STATUS   = 2'd1,
    M_PROG_ARM = 2'd2,
    M_ERAS_ARM = 2'd3
  } cmd_mode_e;

  localparam logic [7:0] OP_PROGRAM  = 8'h40;
  localparam logic [7:0] OP_PROG_ALT = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
endpackage

// File: rtl/flash_wr_strobe.sv
module flash_wr_strobe (
  input  logic clk,
  input  logic pwr_rst_n,
  input  logic chip_sel_n,
  input  logic wr_en_n,
  output logic wr_stb
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (!pwr_rst_n) we_q <= 1'b1;
    else            we_q <= wr_en_n;
  end

  // rising edge of the strobe with the chip selected (R1)
  assign wr_stb = pwr_rst_n && !chip_sel_n && !we_q && wr_en_n;
endmodule

// File: rtl/flash_cmd_wsm.sv
module flash_cmd_wsm
  import flash_fe_pkg::*;
#(
  parameter int AW          = 10,
  parameter int BOOT_WORDS  = 64,
  parameter int BUSY_CYCLES = 8
) (
  input  logic          clk,
  input  logic          pwr_rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          byte_mode,
  input  logic          byte_lane,
  input  logic          unlock_hv,
  input  logic          wr_prot_n,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  output logic          rd_status,
  output logic          ready,
  output logic [7:0]    status
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_LOAD  = CW'(BUSY_CYCLES);
  localparam logic [AW-1:0] BOOT_LIMIT = AW'(BOOT_WORDS);

  cmd_mode_e     mode;
  logic [CW-1:0] busy_cnt;
  logic          err_erase, err_prog, err_lock;
  logic [7:0]    cmd;
  logic          boot_hit, allow, accept;

  assign cmd      = wr_data[7:0];
  assign ready    = (busy_cnt == '0);
  assign boot_hit = (wr_addr < BOOT_LIMIT);
  assign allow    = !boot_hit || unlock_hv || wr_prot_n;
  assign accept   = wr_stb && ready;

  assign mem_we    = accept && (mode == M_PROG_ARM) && allow;
  assign mem_be    = byte_mode ? (byte_lane ? 2'b10 : 2'b01) : 2'b11;
  assign mem_wdata = byte_mode ? {wr_data[7:0], wr_data[7:0]} : wr_data;

  assign rd_status = (mode != M_ARRAY);
  assign status    = {ready, 1'b0, err_erase, err_prog, 2'b00, err_lock, 1'b0};

  always_ff @(posedge clk) begin
    if (!pwr_rst_n) begin
      mode      <= M_ARRAY;
      busy_cnt  <= '0;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_lock  <= 1'b0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (accept) begin
        case (mode)
          M_PROG_ARM: begin
            mode <= M_STATUS;
            if (allow) busy_cnt <= BUSY_LOAD;
            else begin
              err_prog <= 1'b1;
              err_lock <= 1'b1;
            end
          end
          M_ERAS_ARM: begin
            mode <= M_STATUS;
            if (cmd != OP_CONFIRM) begin
              err_erase <= 1'b1;
              err_prog  <= 1'b1;
            end else if (allow) begin
              busy_cnt <= BUSY_LOAD;
            end else begin
              err_erase <= 1'b1;
              err_lock  <= 1'b1;
            end
          end
          default: begin
            case (cmd)
              OP_PROGRAM, OP_PROG_ALT: mode <= M_PROG_ARM;
              OP_ERASE:                mode <= M_ERAS_ARM;
              OP_STATUS:               mode <= M_STATUS;
              OP_CLEAR: begin
                err_erase <= 1'b0;
                err_prog  <= 1'b0;
                err_lock  <= 1'b0;
              end
              default:                 mode <= M_ARRAY;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_fe_pkg::*;
#(
  parameter logic [15:0] MFR_CODE = 16'h0051,
  parameter logic [15:0] DEV_CODE = 16'h22D6
) (
  input  logic        clk,
  input  logic        pwr_rst_n,
  input  logic        sig_hv,
  input  logic        rd_status,
  input  logic        addr0,
  input  logic        byte_mode,
  input  logic        byte_lane,
  input  logic [7:0]  status,
  input  logic [15:0] mem_rdata,
  output logic [15:0] dq_out
);
  rd_src_e     src_q;
  logic        lane_q, bytem_q;
  logic [15:0] idw_q;
  logic [7:0]  stat_q;
  logic [15:0] word;

  always_ff @(posedge clk) begin
    if (!pwr_rst_n) begin
      src_q   <= SRC_ARRAY;
      lane_q  <= 1'b0;
      bytem_q <= 1'b0;
      idw_q   <= '0;
      stat_q  <= '0;
    end else begin
      src_q   <= sig_hv ? SRC_ID : (rd_status ? SRC_STATUS : SRC_ARRAY);
      lane_q  <= byte_lane;
      bytem_q <= byte_mode;
      idw_q   <= addr0 ? DEV_CODE : MFR_CODE;
      stat_q  <= status;
    end
  end

  always_comb begin
    case (src_q)
      SRC_STATUS: word = {8'h00, stat_q};
      SRC_ID:     word = idw_q;
      default:    word = mem_rdata;
    endcase
    if (!bytem_q)                dq_out = word;
    else if (src_q == SRC_ARRAY) dq_out = {8'h00, lane_q ? word[15:8] : word[7:0]};
    else                         dq_out = {8'h00, word[7:0]};
  end
endmodule

// File: rtl/flash_host_front.sv
module flash_host_front
  import flash_fe_pkg::*;
#(
  parameter int          AW          = 10,
  parameter int          BOOT_WORDS  = 64,
  parameter int          BUSY_CYCLES = 8,
  parameter logic [15:0] MFR_CODE    = 16'h0051,
  parameter logic [15:0] DEV_CODE    = 16'h22D6
) (
  input  logic          clk,
  input  logic          pwr_rst_n,
  input  logic          rst_unlock,
  input  logic          chip_sel_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic          wr_prot_n,
  input  logic          sig_hv,
  input  logic          byte_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic          dq_oe_lo,
  output logic          dq_oe_hi,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  logic       wr_stb, rd_status, wsm_ready, byte_mode, byte_lane, unlock_hv, rd_en;
  logic [7:0] status;

  assign byte_mode = !byte_sel_n;
  assign byte_lane = byte_mode && dq_in[15];
  assign unlock_hv = rst_unlock && pwr_rst_n;
  assign mem_addr  = addr;

  assign rd_en    = pwr_rst_n && !chip_sel_n && !out_en_n;
  assign dq_oe_lo = rd_en;
  assign dq_oe_hi = rd_en && byte_sel_n;

  flash_wr_strobe u_stb (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .chip_sel_n(chip_sel_n),
    .wr_en_n(wr_en_n), .wr_stb(wr_stb)
  );

  flash_cmd_wsm #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .BUSY_CYCLES(BUSY_CYCLES)) u_wsm (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .wr_stb(wr_stb), .wr_addr(addr),
    .wr_data(dq_in), .byte_mode(byte_mode), .byte_lane(byte_lane),
    .unlock_hv(unlock_hv), .wr_prot_n(wr_prot_n), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .rd_status(rd_status),
    .ready(wsm_ready), .status(status)
  );

  flash_read_path #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .sig_hv(sig_hv), .rd_status(rd_status),
    .addr0(addr[0]), .byte_mode(byte_mode), .byte_lane(byte_lane),
    .status(status), .mem_rdata(mem_rdata), .dq_out(dq_out)
  );
endmodule

// File: rtl/flash_host_front_chk.sv
module flash_host_front_chk #(
  parameter int AW         = 10,
  parameter int BOOT_WORDS = 64
) (
  input logic          clk,
  input logic          pwr_rst_n,
  input logic          rst_unlock,
  input logic          chip_sel_n,
  input logic          out_en_n,
  input logic          wr_prot_n,
  input logic          byte_sel_n,
  input logic          dq_oe_lo,
  input logic          dq_oe_hi,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          wsm_ready
);
  localparam logic [AW-1:0] BOOT_LIMIT = AW'(BOOT_WORDS);

  always_comb begin
    if (!pwr_rst_n) p_reset_hiz_r4: assert (!dq_oe_lo && !dq_oe_hi);
  end

  p_deselect_hiz_r3: assert property (@(posedge clk)
    (chip_sel_n || out_en_n) |-> (!dq_oe_lo && !dq_oe_hi));

  p_byte_upper_off_r6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !byte_sel_n |-> !dq_oe_hi);

  p_no_write_busy_r11: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !wsm_ready |-> !mem_we);

  p_write_starts_busy_r11: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    mem_we |=> !wsm_ready);

  p_boot_locked_r9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (mem_we && (mem_addr < BOOT_LIMIT)) |-> (rst_unlock || wr_prot_n));

  p_ready_after_reset_r4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !$past(pwr_rst_n) |-> wsm_ready);
endmodule

bind flash_host_front flash_host_front_chk #(.AW(AW), .BOOT_WORDS(BOOT_WORDS)) u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_unlock(rst_unlock), .chip_sel_n(chip_sel_n),
  .out_en_n(out_en_n), .wr_prot_n(wr_prot_n), .byte_sel_n(byte_sel_n),
  .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .mem_addr(mem_addr), .mem_we(mem_we),
  .wsm_ready(wsm_ready)
);

// File: tb/flash_host_front_tb_top.sv
module flash_host_front_tb_top;
  localparam int AW   = 10;
  localparam int BUSY = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic pwr_rst_n = 1'b0, rst_unlock = 1'b0, chip_sel_n = 1'b1, out_en_n = 1'b1;
  logic wr_en_n = 1'b1, wr_prot_n = 1'b1, sig_hv = 1'b0, byte_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out, mem_wdata;
  logic [15:0]   mem_rdata = '0;
  logic          dq_oe_lo, dq_oe_hi, mem_we;
  logic [1:0]    mem_be;
  logic [AW-1:0] mem_addr;

  flash_host_front #(.AW(AW), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_unlock(rst_unlock), .chip_sel_n(chip_sel_n),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .wr_prot_n(wr_prot_n), .sig_hv(sig_hv),
    .byte_sel_n(byte_sel_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem [0:(1<<AW)-1];
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 16'hA000 | 16'(i);
  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) begin
      if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; dq_in = d; chip_sel_n = 1'b0; wr_en_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b1;
    @(negedge clk); chip_sel_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic lane, output logic [15:0] v);
    @(negedge clk); addr = a; dq_in = {lane, 15'h0}; chip_sel_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk); v = dq_out;
    chip_sel_n = 1'b1; out_en_n = 1'b1;
  endtask

  task automatic settle();
    repeat (BUSY + 2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]    kind;   // 0 write, 1 read, 2 wait out busy
    logic          byte_n;
    logic          lane;
    logic          sig;
    logic [AW-1:0] a;
    logic [15:0]   d;
    logic [15:0]   exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h123, 16'h0000, 16'hA123, 4'd4},  // R4 array after reset
    '{2'd1, 1'b0, 1'b0, 1'b0, 10'h123, 16'h0000, 16'h0023, 4'd6},  // R6 low byte
    '{2'd1, 1'b0, 1'b1, 1'b0, 10'h123, 16'h0000, 16'h00A1, 4'd6},  // R6 high byte
    '{2'd1, 1'b1, 1'b0, 1'b1, 10'h000, 16'h0000, 16'h0051, 4'd5},  // R5 maker code
    '{2'd1, 1'b1, 1'b0, 1'b1, 10'h001, 16'h0000, 16'h22D6, 4'd5},  // R5 part code
    '{2'd1, 1'b0, 1'b1, 1'b1, 10'h001, 16'h0000, 16'h00D6, 4'd7},  // R7 lane ignored
    '{2'd1, 1'b0, 1'b1, 1'b1, 10'h000, 16'h0000, 16'h0051, 4'd7},  // R7
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h000, 16'h0070, 16'h0000, 4'd10},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h123, 16'h0000, 16'h0080, 4'd10}, // R10 status
    '{2'd1, 1'b1, 1'b0, 1'b1, 10'h001, 16'h0000, 16'h22D6, 4'd5},  // R5 overrides mode
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h000, 16'h0033, 16'h0000, 4'd10},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h123, 16'h0000, 16'hA123, 4'd10}, // R10 unknown -> array
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h200, 16'h0040, 16'h0000, 4'd2},
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h200, 16'h1234, 16'h0000, 4'd2},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h200, 16'h0000, 16'h0000, 4'd11}, // R11 busy, R13 status
    '{2'd2, 1'b1, 1'b0, 1'b0, 10'h000, 16'h0000, 16'h0000, 4'd11},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h200, 16'h0000, 16'h0080, 4'd13}, // R13
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h000, 16'h00FF, 16'h0000, 4'd10},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h200, 16'h0000, 16'h1234, 4'd2},  // R2 word program
    '{2'd0, 1'b0, 1'b1, 1'b0, 10'h300, 16'h0040, 16'h0000, 4'd2},
    '{2'd0, 1'b0, 1'b1, 1'b0, 10'h300, 16'h005C, 16'h0000, 4'd2},
    '{2'd2, 1'b1, 1'b0, 1'b0, 10'h000, 16'h0000, 16'h0000, 4'd2},
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h000, 16'h00FF, 16'h0000, 4'd10},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h300, 16'h0000, 16'h5C00, 4'd2},  // R2 byte lane write
    '{2'd1, 1'b0, 1'b1, 1'b0, 10'h300, 16'h0000, 16'h005C, 4'd6},  // R6
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h180, 16'h0020, 16'h0000, 4'd12},
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h180, 16'h0077, 16'h0000, 4'd12},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h180, 16'h0000, 16'h00B0, 4'd12}, // R12 bad confirm
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h000, 16'h0050, 16'h0000, 4'd10},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h180, 16'h0000, 16'h0080, 4'd10}, // R10 clear
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h180, 16'h0020, 16'h0000, 4'd12},
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h180, 16'h00D0, 16'h0000, 4'd12},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h180, 16'h0000, 16'h0000, 4'd12}, // R12 erase busy
    '{2'd2, 1'b1, 1'b0, 1'b0, 10'h000, 16'h0000, 16'h0000, 4'd12},
    '{2'd1, 1'b1, 1'b0, 1'b0, 10'h180, 16'h0000, 16'h0080, 4'd12},
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h000, 16'h00FF, 16'h0000, 4'd10}
  };

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    // R4: outputs off while the reset pin is low
    repeat (3) @(negedge clk);
    chip_sel_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    check({14'h0, dq_oe_hi, dq_oe_lo}, 16'h0000, 4);
    chip_sel_n = 1'b1; out_en_n = 1'b1;
    pwr_rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      byte_sel_n = VECS[i].byte_n;
      sig_hv     = VECS[i].sig;
      case (VECS[i].kind)
        2'd0: wr(VECS[i].a, {VECS[i].lane, VECS[i].d[14:0]});
        2'd1: begin rd(VECS[i].a, VECS[i].lane, v); check(v, VECS[i].exp, int'(VECS[i].req)); end
        default: settle();
      endcase
    end
    byte_sel_n = 1'b1; sig_hv = 1'b0;

    // R3: enables follow select and output enable
    @(negedge clk); chip_sel_n = 1'b1; out_en_n = 1'b0;
    #1 check({14'h0, dq_oe_hi, dq_oe_lo}, 16'h0000, 3);
    chip_sel_n = 1'b0; out_en_n = 1'b1;
    #1 check({14'h0, dq_oe_hi, dq_oe_lo}, 16'h0000, 3);
    out_en_n = 1'b0;
    #1 check({14'h0, dq_oe_hi, dq_oe_lo}, 16'h0003, 3);
    byte_sel_n = 1'b0;
    #1 check({14'h0, dq_oe_hi, dq_oe_lo}, 16'h0001, 6);
    byte_sel_n = 1'b1; chip_sel_n = 1'b1; out_en_n = 1'b1;

    // R1: strobe without chip select is ignored
    @(negedge clk); addr = '0; dq_in = 16'h0070; wr_en_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b1;
    rd(10'h123, 1'b0, v); check(v, 16'hA123, 1);

    // R9: boot region locked
    wr_prot_n = 1'b0;
    wr(10'h010, 16'h0040); wr(10'h010, 16'hBEEF);
    rd(10'h010, 1'b0, v); check(v, 16'h0092, 9);
    wr(10'h000, 16'h00FF);
    rd(10'h010, 1'b0, v); check(v, 16'hA010, 9);
    wr(10'h000, 16'h0070); wr(10'h000, 16'h0050);
    rd(10'h010, 1'b0, v); check(v, 16'h0080, 10);
    wr(10'h010, 16'h0020); wr(10'h010, 16'h00D0);
    rd(10'h010, 1'b0, v); check(v, 16'h00A2, 9);
    wr(10'h000, 16'h0050);

    // R8: unlock level overrides write protect
    rst_unlock = 1'b1;
    wr(10'h010, 16'h0040); wr(10'h010, 16'hBEEF);
    rd(10'h010, 1'b0, v); check(v, 16'h0000, 8);
    settle();
    rd(10'h010, 1'b0, v); check(v, 16'h0080, 8);
    wr(10'h000, 16'h00FF);
    rd(10'h010, 1'b0, v); check(v, 16'hBEEF, 8);
    rst_unlock = 1'b0; wr_prot_n = 1'b1;

    // R11: program command during busy is dropped
    wr(10'h200, 16'h0040); wr(10'h200, 16'h1111);
    wr(10'h200, 16'h0040);
    settle();
    wr(10'h200, 16'h2222);
    rd(10'h200, 1'b0, v); check(v, 16'h1111, 11);

    // R4: reset in the middle of a busy window
    wr(10'h220, 16'h0040); wr(10'h220, 16'h7777);
    @(negedge clk); pwr_rst_n = 1'b0;
    repeat (2) @(negedge clk); pwr_rst_n = 1'b1;
    rd(10'h220, 1'b0, v); check(v, 16'h7777, 4);
    wr(10'h000, 16'h0070);
    rd(10'h220, 1'b0, v); check(v, 16'h0080, 4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule